// File: doc/BRIEF.md
# Sensor Sample FIFO with Read-Clear Status

This block buffers multi-axis sensor samples between the sampling logic and a host. Each accepted sample is pushed on a write strobe; the host pops the oldest one through a pop strobe and sees it on a registered data output one cycle later. An 8-bit status byte tells the host how many samples are waiting, and carries two sticky event flags: one for a sample that arrived with no room left, and one for a fill level that has reached a programmable threshold.

The host fetches the status byte through a small read port. The byte lives at address 0x08. While the buffer is enabled it is also visible at address 0x00, so that a host draining the buffer can keep polling the primary status location. Reading the status clears both flags. A pulse marking entry into the active operating mode resets the stored count, the flags and the buffer pointers.

Top module: `sensor_fifo_stat`

## Requirements
- R1: After reset, a status read at 0x08 returns 0x00. Status byte layout: bit 7 overflow flag, bit 6 watermark flag, bits 5:0 the number of stored samples (0 means empty).
- R2: While `fifo_en` is high, each `wr_stb` stores `wr_data` and raises the count by one. Each `pop_stb` on a non-empty buffer lowers the count by one and drives the oldest stored sample on `pop_data` in the following cycle. The count never exceeds DEPTH.
- R3: A `wr_stb` while enabled with the count at DEPTH and no pop in the same cycle sets the overflow flag, discards the new sample and leaves the count at DEPTH and the stored samples unchanged.
- R4: A `pop_stb` on an empty buffer drives 0 on `pop_data` in the following cycle and leaves the count at 0.
- R5: While enabled with a nonzero `wmrk`, the watermark flag is set in the cycle the count becomes greater than or equal to `wmrk`, and stays set until cleared. A `wmrk` of 0 sets nothing.
- R6: A status read (0x08, or 0x00 while enabled) returns the byte as it stood before the read and then clears both flags, except that a flag whose set condition holds in the read cycle stays 1.
- R7: While `fifo_en` is low the watermark flag is held at 0 and `wr_stb` is ignored (count unchanged).
- R8: A read at 0x00 returns the status byte while enabled and 0x00 while disabled; any address other than 0x00 and 0x08 returns 0x00. `host_rdata` is valid the cycle after `host_re`.
- R9: An `act_entry` pulse sets the count, both flags and the buffer pointers to zero, overriding any write or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Buffer enable |
| wmrk | input | 6 | Watermark threshold in samples |
| act_entry | input | 1 | Pulse marking entry into active mode |
| wr_stb | input | 1 | New sample strobe |
| wr_data | input | SW | New sample |
| pop_stb | input | 1 | Pop the oldest sample |
| pop_data | output | SW | Popped sample, valid the cycle after `pop_stb` |
| host_re | input | 1 | Status read strobe |
| host_addr | input | 8 | Status read address |
| host_rdata | output | 8 | Read data, valid the cycle after `host_re` |

## Verification
The bench builds the block with DEPTH of 8 and a 12-bit sample, so a full buffer and its overflow are reached in a few writes and sample values wider than the status byte prove the data path is not truncated. A watermark of 3 lets the threshold be crossed in both directions within a short sequence, exposing the sticky hold after pops and the re-set that wins over a clearing read. The mirror address is read both enabled and disabled, and the mode-entry pulse is applied to a partly filled buffer.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam logic [7:0] ADDR_STAT = 8'h08;
  localparam logic [7:0] ADDR_MIRR = 8'h00;
  localparam int         CNT_FIELD = 6;

  typedef struct packed {
    logic                 ovf;
    logic                 wmk;
    logic [CNT_FIELD-1:0] cnt;
  } stat_t;
endpackage

// File: rtl/sfs_store.sv
module sfs_store #(
  parameter int SW    = 8,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [SW-1:0] wdata,
  input  logic          pop,
  output logic [SW-1:0] rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [SW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [SW-1:0] ram_q;
  logic          pv;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
    if (pop)  ram_q     <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      pv   <= 1'b0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      pv <= pop;
    end
  end

  assign rdata = pv ? ram_q : '0;
endmodule

// File: rtl/sfs_count.sv
module sfs_count #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] FULL_V = CW'(DEPTH);

  always_comb begin
    unique case ({push, pop})
      2'b10:   cnt_nxt = cnt + 1'b1;
      2'b01:   cnt_nxt = cnt - 1'b1;
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt_nxt;
  end

  assign full  = (cnt == FULL_V);
  assign empty = (cnt == '0);
endmodule

// File: rtl/sfs_flags.sv
module sfs_flags #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [5:0]    wmrk,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          ovf_evt,
  input  logic          stat_rd,
  output logic          ovf,
  output logic          wmk
);
  localparam int MW = (CW > 6) ? CW : 6;

  logic wm_hit;
  assign wm_hit = en && (wmrk != '0) && (MW'(cnt_nxt) >= MW'(wmrk));

  always_ff @(posedge clk) begin
    if (rst || clr)   ovf <= 1'b0;
    else if (ovf_evt) ovf <= 1'b1;
    else if (stat_rd) ovf <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)             wmk <= 1'b0;
    else if (wm_hit)            wmk <= 1'b1;
    else if (stat_rd || !en)    wmk <= 1'b0;
  end
endmodule

// File: rtl/sfs_regs.sv
module sfs_regs
  import sfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       host_re,
  input  logic [7:0] host_addr,
  input  logic       en,
  input  stat_t      stat,
  output logic       stat_rd,
  output logic [7:0] host_rdata
);
  logic hit_main, hit_mirr;
  assign hit_main = (host_addr == ADDR_STAT);
  assign hit_mirr = (host_addr == ADDR_MIRR) && en;
  assign stat_rd  = host_re && (hit_main || hit_mirr);

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_re) host_rdata <= stat_rd ? stat : 8'h00;
  end
endmodule

// File: rtl/sensor_fifo_stat.sv
module sensor_fifo_stat
  import sfs_pkg::*;
#(
  parameter int SW    = 8,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [5:0]    wmrk,
  input  logic          act_entry,
  input  logic          wr_stb,
  input  logic [SW-1:0] wr_data,
  input  logic          pop_stb,
  output logic [SW-1:0] pop_data,
  input  logic          host_re,
  input  logic [7:0]    host_addr,
  output logic [7:0]    host_rdata
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          push_ok, pop_ok, ovf_evt, stat_rd;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          full, empty, ovf, wmk;
  stat_t         stat;

  assign pop_ok  = pop_stb && !empty && !act_entry;
  assign push_ok = wr_stb && fifo_en && !act_entry && (!full || pop_ok);
  assign ovf_evt = wr_stb && fifo_en && !act_entry && full && !pop_ok;

  sfs_store #(.SW(SW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .clr(act_entry),
    .push(push_ok), .wdata(wr_data), .pop(pop_ok), .rdata(pop_data)
  );

  sfs_count #(.DEPTH(DEPTH), .CW(CW)) u_count (
    .clk(clk), .rst(rst), .clr(act_entry),
    .push(push_ok), .pop(pop_ok),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .full(full), .empty(empty)
  );

  sfs_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst(rst), .clr(act_entry), .en(fifo_en), .wmrk(wmrk),
    .cnt_nxt(cnt_nxt), .ovf_evt(ovf_evt), .stat_rd(stat_rd),
    .ovf(ovf), .wmk(wmk)
  );

  assign stat = '{ovf: ovf, wmk: wmk, cnt: CNT_FIELD'(cnt)};

  sfs_regs u_regs (
    .clk(clk), .rst(rst), .host_re(host_re), .host_addr(host_addr),
    .en(fifo_en), .stat(stat), .stat_rd(stat_rd), .host_rdata(host_rdata)
  );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int SW    = 8,
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic [5:0]    wmrk,
  input logic          act_entry,
  input logic          wr_stb,
  input logic          pop_stb,
  input logic [SW-1:0] pop_data,
  input logic          host_re,
  input logic [7:0]    host_addr,
  input logic [7:0]    host_rdata,
  input logic [CW-1:0] cnt,
  input logic          ovf,
  input logic          wmk
);
  localparam logic [CW-1:0] FULL_V = CW'(DEPTH);
  localparam int MW = (CW > 6) ? CW : 6;

  always_comb begin
    if (!rst) assert_count_bound_R2: assert (cnt <= FULL_V);
  end

  assert_overflow_keep_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && fifo_en && !act_entry && !pop_stb && cnt == FULL_V) |=> (cnt == FULL_V && ovf));

  assert_empty_pop_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (pop_stb && cnt == '0) |=> (pop_data == '0));

  assert_wmk_set_R5: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && wmrk != '0 && !act_entry) |=> (MW'(cnt) < MW'($past(wmrk)) || wmk));

  assert_read_clears_ovf_R6: assert property (@(posedge clk) disable iff (rst)
    (host_re && host_addr == 8'h08 && !wr_stb) |=> !ovf);

  assert_disable_wmk_R7: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> !wmk);

  assert_mirror_off_R8: assert property (@(posedge clk) disable iff (rst)
    (host_re && host_addr == 8'h00 && !fifo_en) |=> (host_rdata == 8'h00));

  assert_act_clear_R9: assert property (@(posedge clk) disable iff (rst)
    act_entry |=> (cnt == '0 && !ovf && !wmk));
endmodule

bind sensor_fifo_stat sfs_checker #(.SW(SW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .wmrk(wmrk), .act_entry(act_entry),
  .wr_stb(wr_stb), .pop_stb(pop_stb), .pop_data(pop_data),
  .host_re(host_re), .host_addr(host_addr), .host_rdata(host_rdata),
  .cnt(cnt), .ovf(ovf), .wmk(wmk)
);

// File: tb/sensor_fifo_stat_test.sv
module sensor_fifo_stat_test;
  localparam int SW    = 12;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fifo_en = 1'b0;
  logic [5:0]    wmrk = 6'd3;
  logic          act_entry = 1'b0;
  logic          wr_stb = 1'b0;
  logic [SW-1:0] wr_data = '0;
  logic          pop_stb = 1'b0;
  logic [SW-1:0] pop_data;
  logic          host_re = 1'b0;
  logic [7:0]    host_addr = '0;
  logic [7:0]    host_rdata;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sensor_fifo_stat #(.SW(SW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .wmrk(wmrk), .act_entry(act_entry),
    .wr_stb(wr_stb), .wr_data(wr_data), .pop_stb(pop_stb), .pop_data(pop_data),
    .host_re(host_re), .host_addr(host_addr), .host_rdata(host_rdata)
  );

  // op: 0 write, 1 pop (exp = pop_data), 2 read (exp = host_rdata)
  localparam int NV = 13;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 8'h00, 12'h101, 12'h000},
    {2'd0, 8'h00, 12'h202, 12'h000},
    {2'd2, 8'h08, 12'h000, 12'h002},
    {2'd0, 8'h00, 12'h303, 12'h000},
    {2'd2, 8'h00, 12'h000, 12'h043},
    {2'd1, 8'h00, 12'h000, 12'h101},
    {2'd2, 8'h08, 12'h000, 12'h042},
    {2'd2, 8'h08, 12'h000, 12'h002},
    {2'd1, 8'h00, 12'h000, 12'h202},
    {2'd1, 8'h00, 12'h000, 12'h303},
    {2'd1, 8'h00, 12'h000, 12'h000},
    {2'd2, 8'h08, 12'h000, 12'h000},
    {2'd2, 8'h05, 12'h000, 12'h000}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [SW-1:0] d);
    wr_stb = 1'b1; wr_data = d;
    step();
    wr_stb = 1'b0;
  endtask

  task automatic do_pop(input string tag, input logic [SW-1:0] exp);
    pop_stb = 1'b1;
    step();
    pop_stb = 1'b0;
    check(tag, pop_data, exp);
  endtask

  task automatic do_rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    host_re = 1'b1; host_addr = a;
    step();
    host_re = 1'b0;
    check(tag, {4'h0, host_rdata}, {4'h0, exp});
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1: reset state
    do_rd("R1 reset status", 8'h08, 8'h00);
    fifo_en = 1'b1;
    step();

    // table: R2 order, R5 watermark, R6 read-clear, R8 mirror, R4 empty pop
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [7:0]  ad;
      logic [11:0] dt, ex;
      {op, ad, dt, ex} = VEC[i];
      case (op)
        2'd0: do_wr(dt);
        2'd1: do_pop($sformatf("R2 R4 vector %0d pop", i), ex);
        default: do_rd($sformatf("R5 R6 R8 vector %0d read", i), ad, ex[7:0]);
      endcase
    end

    // R3: fill and overflow
    for (int k = 1; k <= DEPTH; k++) do_wr(SW'(12'hA00 + k));
    do_wr(12'hBAD);
    do_rd("R3 overflow flag set", 8'h08, 8'hC8);
    do_rd("R6 ovf cleared, wmk held", 8'h08, 8'h48);
    // R6: set wins over clear in same cycle
    wr_stb = 1'b1; wr_data = 12'hBEE; host_re = 1'b1; host_addr = 8'h08;
    step();
    wr_stb = 1'b0; host_re = 1'b0;
    check("R6 read during overflow", {4'h0, host_rdata}, 12'h048);
    do_rd("R6 set wins over clear", 8'h08, 8'hC8);
    for (int k = 1; k <= DEPTH; k++)
      do_pop($sformatf("R3 kept sample %0d", k), SW'(12'hA00 + k));
    do_pop("R4 empty pop", 12'h000);
    do_rd("R5 wmk sticky after drain", 8'h08, 8'h40);
    do_rd("R6 wmk cleared", 8'h08, 8'h00);

    // R7: disable
    for (int k = 0; k < 4; k++) do_wr(SW'(12'hC00 + k));
    fifo_en = 1'b0;
    step();
    do_rd("R8 mirror while disabled", 8'h00, 8'h00);
    do_rd("R7 wmk cleared on disable", 8'h08, 8'h04);
    do_wr(12'hDDD);
    do_rd("R7 write ignored while disabled", 8'h08, 8'h04);
    fifo_en = 1'b1;
    step();
    do_rd("R5 wmk on re-enable", 8'h00, 8'h44);

    // R9: mode entry
    act_entry = 1'b1;
    step();
    act_entry = 1'b0;
    do_rd("R9 status after mode entry", 8'h08, 8'h00);
    do_pop("R9 pop after mode entry", 12'h000);
    do_wr(12'h777);
    do_pop("R9 pointers restart", 12'h777);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule